// File: doc/BRIEF.md
# Selectable-Port POST Code Capture

This block listens to I/O write cycles on an ISA bus and keeps the bytes that the host firmware writes to one diagnostic port during power-on self test. The port is picked at run time by a 3-bit switch code from eight legacy port addresses. The three most recent bytes are kept newest first, each with a valid flag, so that a display stage can show a short history of progress codes.

All bus inputs are asynchronous to the card clock. IOW#, AEN and the address and data buses pass through a synchronizer, one extra delay stage and an edge detector before the history is updated. The 12-bit address of the selected port is brought out as well, so that a display mode can show which port is being watched. Any change of the switch code empties the history, so codes taken from different ports are never mixed.

Top module: `post_capture`

## Requirements
- R1: While `rst` is high at a clock edge, all three `code_valid` bits become 0, all code bytes become 00h and `port_addr` becomes 080h.
- R2: One clock edge after `port_sel` changes, `port_addr` shows the selected port. The select value is read as sel[0] = switch 1, sel[1] = switch 2, sel[2] = switch 3, with 1 meaning ON. The ports by value are 0: 080h, 1: 084h, 2: 090h, 3: 300h, 4: 680h, 5: 060h, 6: 190h and 7: 378h.
- R3: A rising edge of `isa_iow_n` while `isa_aen` is low and `isa_addr[15:0]` equals the selected port captures `isa_data` into `code0`. The capture is visible after the third clock edge that follows the rise.
- R4: Each capture moves `code0` into `code1` and `code1` into `code2`. The old `code2` is dropped.
- R5: `code_valid[i]` belongs to slot i. It is set once a code has moved into that slot, and a set bit i implies that bit i-1 is also set.
- R6: A write made while `isa_aen` is high changes no code and no valid bit.
- R7: A write whose `isa_addr[15:0]` differs from the selected port is ignored, including a difference only in bits 15..12. Bits 19..16 are not decoded.
- R8: A single low pulse of `isa_iow_n` gives exactly one capture, however many clocks it lasts.
- R9: A change of `port_sel` clears all valid bits and codes at the next clock edge. The clear wins over a capture at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst | input | 1 | Synchronous active-high reset |
| isa_addr | input | 20 | ISA address bus |
| isa_data | input | 8 | ISA data bus |
| isa_iow_n | input | 1 | I/O write strobe, active low |
| isa_aen | input | 1 | DMA address enable, high blocks decode |
| port_sel | input | 3 | Switch code choosing the watched port |
| code0 | output | 8 | Newest captured code |
| code1 | output | 8 | Second newest code |
| code2 | output | 8 | Oldest kept code |
| code_valid | output | 3 | Valid flag per slot, bit i for code i |
| port_addr | output | 12 | Address of the selected port |

## Verification
A capture lands on the history outputs after the third clock edge that follows the rise of the write strobe. A switch change shows on the port address and clears the history one edge later. The bench keeps a queue of the inputs it drove at each edge and derives the expected state from entries one, two and three edges old, so the reference carries the same latency as the design and is compared at every falling edge. Directed checks are read only after the write task has waited four edges past the strobe rise.

// File: rtl/post_capture_pkg.sv
package post_capture_pkg;

  localparam int ISA_ADDR_W = 20;
  localparam int ISA_DATA_W = 8;
  localparam int SEL_W      = 3;
  localparam int PORT_W     = 12;

  function automatic logic [PORT_W-1:0] port_for_sel(input logic [SEL_W-1:0] sel);
    logic [PORT_W-1:0] p;
    case (sel)
      3'd0:    p = 12'h080;
      3'd1:    p = 12'h084;
      3'd2:    p = 12'h090;
      3'd3:    p = 12'h300;
      3'd4:    p = 12'h680;
      3'd5:    p = 12'h060;
      3'd6:    p = 12'h190;
      default: p = 12'h378;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/post_sync.sv
module post_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] dly_o
);

  logic [W-1:0] stage [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= IDLE;
        else     stage[i] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= IDLE;
        else     stage[i] <= stage[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dly_o <= IDLE;
    else     dly_o <= stage[STAGES-1];
  end

  assign sync_o = stage[STAGES-1];

endmodule

// File: rtl/post_port_sel.sv
module post_port_sel
  import post_capture_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [SEL_W-1:0]  sel,
  output logic [PORT_W-1:0] port_q,
  output logic              sel_change
);

  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      port_q <= port_for_sel('0);
    end else begin
      sel_q  <= sel;
      port_q <= port_for_sel(sel);
    end
  end

  assign sel_change = (sel != sel_q);

  AST_PORT_FOLLOWS_SEL: assert property (@(posedge clk) disable iff (rst)
    $stable(sel) && !$past(rst) |=> $stable(port_q)) else $error("port moved without select change"); // R2

endmodule

// File: rtl/post_history.sv
module post_history #(
  parameter int DEPTH = 3,
  parameter int DW    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                push,
  input  logic [DW-1:0]       din,
  output logic [DEPTH*DW-1:0] codes_o,
  output logic [DEPTH-1:0]    valid_o
);

  logic [DW-1:0]    slot [DEPTH];
  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (push) begin
      slot[0] <= din;
      for (int i = 1; i < DEPTH; i++) slot[i] <= slot[i-1];
      vld <= {vld[DEPTH-2:0], 1'b1};
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_out
    assign codes_o[i*DW +: DW] = slot[i];
  end
  assign valid_o = vld;

  AST_RESET_EMPTY: assert property (@(posedge clk)
    rst |=> (vld == '0)) else $error("history not empty after reset"); // R1

  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (rst)
    push && !clear |=> (slot[1] == $past(slot[0])) && (slot[2] == $past(slot[1]))) else $error("shift order"); // R4

  AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (rst)
    clear |=> (vld == '0)) else $error("clear left valid bits"); // R9

  for (genvar i = 1; i < DEPTH; i++) begin : g_thermo
    AST_VALID_THERMO: assert property (@(posedge clk) disable iff (rst)
      vld[i] |-> vld[i-1]) else $error("valid bits out of order"); // R5
  end

endmodule

// File: rtl/post_capture.sv
module post_capture
  import post_capture_pkg::*;
#(
  parameter int DECODE_W    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ISA_ADDR_W-1:0] isa_addr,
  input  logic [ISA_DATA_W-1:0] isa_data,
  input  logic                  isa_iow_n,
  input  logic                  isa_aen,
  input  logic [SEL_W-1:0]      port_sel,
  output logic [ISA_DATA_W-1:0] code0,
  output logic [ISA_DATA_W-1:0] code1,
  output logic [ISA_DATA_W-1:0] code2,
  output logic [2:0]            code_valid,
  output logic [PORT_W-1:0]     port_addr
);

  localparam int DEPTH  = 3;
  localparam int BUS_W  = 2 + ISA_ADDR_W + ISA_DATA_W;
  localparam int IOW_B  = BUS_W - 1;
  localparam int AEN_B  = BUS_W - 2;
  localparam logic [BUS_W-1:0] BUS_IDLE = {1'b1, 1'b1, {(ISA_ADDR_W + ISA_DATA_W){1'b0}}};

  logic [BUS_W-1:0] bus_in, bus_now, bus_prev;
  logic [PORT_W-1:0] port_q;
  logic sel_change, rise, hit;
  logic [ISA_DATA_W-1:0] cap_data;
  logic [DECODE_W-1:0] cap_addr;
  logic [DEPTH*ISA_DATA_W-1:0] codes;

  assign bus_in = {isa_iow_n, isa_aen, isa_addr, isa_data};

  post_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .IDLE(BUS_IDLE)) u_sync (
    .clk(clk), .rst(rst), .din(bus_in), .sync_o(bus_now), .dly_o(bus_prev)
  );

  post_port_sel u_sel (
    .clk(clk), .rst(rst), .sel(port_sel), .port_q(port_q), .sel_change(sel_change)
  );

  assign rise     = bus_now[IOW_B] & ~bus_prev[IOW_B];
  assign cap_data = bus_prev[ISA_DATA_W-1:0];
  assign cap_addr = bus_prev[ISA_DATA_W +: DECODE_W];
  assign hit      = rise && !bus_prev[AEN_B] &&
                    (cap_addr == {{(DECODE_W-PORT_W){1'b0}}, port_q});

  post_history #(.DEPTH(DEPTH), .DW(ISA_DATA_W)) u_hist (
    .clk(clk), .rst(rst), .clear(sel_change), .push(hit), .din(cap_data),
    .codes_o(codes), .valid_o(code_valid)
  );

  assign code0     = codes[0 +: ISA_DATA_W];
  assign code1     = codes[ISA_DATA_W +: ISA_DATA_W];
  assign code2     = codes[2*ISA_DATA_W +: ISA_DATA_W];
  assign port_addr = port_q;

  AST_SINGLE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise) else $error("two captures from one strobe"); // R8

  AST_CAPTURE_NEWEST: assert property (@(posedge clk) disable iff (rst)
    hit && !sel_change |=> (code0 == $past(cap_data)) && code_valid[0]) else $error("newest code wrong"); // R3

  AST_AEN_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    rise && bus_prev[AEN_B] && !sel_change |=> $stable(codes) && $stable(code_valid)) else $error("DMA cycle captured"); // R6

  AST_ADDR_MISS: assert property (@(posedge clk) disable iff (rst)
    rise && (cap_addr != {{(DECODE_W-PORT_W){1'b0}}, port_q}) && !sel_change |=> $stable(codes)) else $error("wrong port captured"); // R7

endmodule

// File: tb/post_capture_bench.sv
module post_capture_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [19:0] addr = '0;
  logic [7:0]  data = '0;
  logic iow_n = 1'b1;
  logic aen = 1'b1;
  logic [2:0] sel = '0;
  logic [7:0] code0, code1, code2;
  logic [2:0] code_valid;
  logic [11:0] port_addr;

  post_capture u_post_capture (
    .clk(clk), .rst(rst), .isa_addr(addr), .isa_data(data), .isa_iow_n(iow_n),
    .isa_aen(aen), .port_sel(sel), .code0(code0), .code1(code1), .code2(code2),
    .code_valid(code_valid), .port_addr(port_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  typedef struct {bit rst; bit iow_n; bit aen; bit [19:0] addr; bit [7:0] data; bit [2:0] sel;} smp_t;
  smp_t hq[$];
  int m_code[3];
  bit m_val[3];
  int m_port = 'h080;

  function automatic int port_ref(input int s);
    case (s)
      0: return 'h080;  1: return 'h084;  2: return 'h090;  3: return 'h300;
      4: return 'h680;  5: return 'h060;  6: return 'h190;  default: return 'h378;
    endcase
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 3; i++) begin m_code[i] = 0; m_val[i] = 0; end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    smp_t idle;
    idle = '{1'b1, 1'b1, 1'b1, 20'h0, 8'h0, 3'd0};
    for (int i = 0; i < 4; i++) hq.push_back(idle);
    model_clear();
  end

  // reference model: inputs seen one, two and three edges ago
  always @(posedge clk) begin
    smp_t n;
    int prev_sel, cur_port;
    n = '{rst, iow_n, aen, addr, data, sel};
    hq.push_front(n);
    void'(hq.pop_back());
    if (n.rst) begin
      model_clear();
      m_port = 'h080;
    end else begin
      prev_sel = hq[1].rst ? 0 : int'(hq[1].sel);
      cur_port = hq[1].rst ? 'h080 : port_ref(int'(hq[1].sel));
      if (int'(n.sel) != prev_sel) model_clear();
      else if (!hq[1].rst && !hq[2].rst && !hq[3].rst && hq[2].iow_n && !hq[3].iow_n &&
               !hq[3].aen && int'(hq[3].addr[15:0]) == cur_port) begin
        m_code[2] = m_code[1]; m_code[1] = m_code[0]; m_code[0] = int'(hq[3].data);
        m_val[2] = m_val[1]; m_val[1] = m_val[0]; m_val[0] = 1'b1;
      end
      m_port = port_ref(int'(n.sel));
    end
  end

  always @(negedge clk) begin
    chk({cur_req, " code0"}, int'(code0), m_code[0]);
    chk({cur_req, " code1"}, int'(code1), m_code[1]);
    chk({cur_req, " code2"}, int'(code2), m_code[2]);
    chk({cur_req, " valid"}, int'(code_valid), {29'd0, m_val[2], m_val[1], m_val[0]});
    chk({cur_req, " port"}, int'(port_addr), m_port);
  end

  task automatic io_write(input logic [19:0] a, input logic [7:0] d, input logic a_en, input int low_cycles);
    @(negedge clk); addr = a; data = d; aen = a_en;
    @(negedge clk); iow_n = 1'b0;
    repeat (low_cycles) @(negedge clk);
    iow_n = 1'b1;
    repeat (4) @(negedge clk);
    aen = 1'b1;
  endtask

  task automatic set_sel(input logic [2:0] s);
    @(negedge clk); sel = s;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after reset", int'(code_valid), 0);
    chk("R1 port after reset", int'(port_addr), 'h080);

    cur_req = "R3";
    io_write(20'h00080, 8'h11, 1'b0, 2);
    chk("R3 code0", int'(code0), 'h11);
    chk("R5 one valid", int'(code_valid), 'b001);

    cur_req = "R4";
    io_write(20'h00080, 8'h22, 1'b0, 1);
    chk("R5 two valid", int'(code_valid), 'b011);
    io_write(20'h00080, 8'h33, 1'b0, 3);
    io_write(20'h00080, 8'h44, 1'b0, 1);
    chk("R4 code0", int'(code0), 'h44);
    chk("R4 code1", int'(code1), 'h33);
    chk("R4 code2 oldest dropped", int'(code2), 'h22);
    chk("R5 all valid", int'(code_valid), 'b111);

    cur_req = "R6";
    io_write(20'h00080, 8'h55, 1'b1, 2);
    chk("R6 aen high ignored", int'(code0), 'h44);

    cur_req = "R7";
    io_write(20'h01080, 8'h66, 1'b0, 2);
    chk("R7 bit12 differs ignored", int'(code0), 'h44);
    io_write(20'h00081, 8'h67, 1'b0, 2);
    chk("R7 low bit differs ignored", int'(code0), 'h44);
    io_write(20'h50080, 8'h68, 1'b0, 2);
    chk("R7 upper bits not decoded", int'(code0), 'h68);

    cur_req = "R8";
    io_write(20'h00080, 8'h77, 1'b0, 12);
    chk("R8 long pulse code0", int'(code0), 'h77);
    chk("R8 long pulse single shift", int'(code1), 'h68);

    cur_req = "R9";
    set_sel(3'd4);
    chk("R9 valid cleared", int'(code_valid), 0);
    chk("R2 sel4 port", int'(port_addr), 'h680);
    cur_req = "R3";
    io_write(20'h00080, 8'h88, 1'b0, 2);
    chk("R7 old port ignored", int'(code_valid), 0);
    io_write(20'h00680, 8'h99, 1'b0, 2);
    chk("R3 port 680h bit10", int'(code0), 'h99);

    cur_req = "R2";
    for (int s = 0; s < 8; s++) begin
      set_sel(s[2:0]);
      chk("R2 port table", int'(port_addr), port_ref(s));
    end
    io_write(20'h00378, 8'hA5, 1'b0, 2);
    chk("R3 port 378h", int'(code0), 'hA5);

    cur_req = "R9";
    @(negedge clk); addr = 20'h00378; data = 8'h5A; aen = 1'b0;
    @(negedge clk); iow_n = 1'b0;
    @(negedge clk); iow_n = 1'b1;
    @(negedge clk); @(negedge clk); sel = 3'd0;
    repeat (4) @(negedge clk); aen = 1'b1;
    chk("R9 clear wins over capture", int'(code_valid), 0);

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule